// File: doc/BRIEF.md
# Serial-Code Program/Verify Mode Controller

This block models the programming-mode front end of a small one-time-programmable memory. A 10-bit mode code is shifted in serially while a sync strobe is held low. When sync goes high again, the code picks one of three targets: a 1K-byte user array, a 64-byte key array, or a pair of security bits. The level of a high-voltage-present flag then decides what happens. With the flag high, a correctly timed low pulse on the program strobe burns data into the selected target. With the flag low, the block presents verify data on an output byte.

Programming can only clear bits. An erased cell reads 0xFF, and a burn stores the AND of the old and new bytes. A strobe pulse whose low time falls outside a window set by parameters, counted in clock cycles, is refused. A refused pulse sets a sticky error flag and changes no storage. An unrecognised code puts the block in an idle mode. In idle mode strobes do nothing and the verify byte reads zero.

Top module: `otp_mode_ctrl`

## Requirements
- R1: While `sync_n` is low, the code register shifts `ser_in` in MSB first on each rising clock edge. On the first edge at which `sync_n` is sampled high after having been low, the last 10 bits shifted in become the active mode.
- R2: Code 0x296 selects the user array, indexed by the full `addr`. With `hv_en`=1, an accepted strobe pulse burns `din` at `addr`. With `hv_en`=0, `dout` shows the byte stored at `addr`.
- R3: Code 0x292 selects the key array, indexed by `addr[5:0]`. It is a storage separate from the user array and has the same program/verify split.
- R4: With `hv_en`=1 and an accepted pulse, code 0x29A sets security bit 1 and code 0x298 sets security bit 2. Neither burn depends on `addr` or `din`, and neither changes either array.
- R5: Code 0x29A with `hv_en`=0 gives `dout` = {sec1, sec2, 6'b000000}, where bit 7 is security bit 1 and bit 6 is security bit 2. A set security bit stays set until reset. Code 0x298 with `hv_en`=0 gives `dout`=0x00.
- R6: After reset every array byte reads 0xFF, and a burn stores (old AND `din`).
- R7: The pulse width is the number of rising edges at which `prog_n` is sampled low. A width below PW_MIN or above PW_MAX is refused: it sets `err_flag` and leaves all storage unchanged. The widths PW_MIN and PW_MAX are themselves accepted.
- R8: `err_flag` stays high once set, until reset.
- R9: Any other code selects idle mode. In idle mode, strobe pulses of any width change no storage and leave `err_flag` alone, and `dout` reads 0x00.
- R10: Reset (`rst_n` low) clears the mode to idle, `dout` to 0x00 and `err_flag` to 0, and erases both arrays and both security bits.
- R11: `dout` is registered. It reflects the mode, `addr` and `hv_en` sampled one clock edge earlier, which is well inside a 14-cycle verify budget. `dout` reads 0x00 whenever `hv_en` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial mode-code bit |
| sync_n | input | 1 | Shift enable when low; mode latch on return high |
| prog_n | input | 1 | Program strobe, active-low pulse |
| hv_en | input | 1 | 1 = program voltage present, 0 = normal level (verify) |
| addr | input | 10 | Byte address |
| din | input | 8 | Byte to burn |
| dout | output | 8 | Verify data byte |
| err_flag | output | 1 | Sticky refused-pulse flag |

## Verification
The bench builds the block with PW_MIN=4 and PW_MAX=8 in place of the default window. The default window counts hundreds of cycles, while this one puts the four edge widths 3, 4, 8 and 9 within a few cycles each. That leaves room for the whole mix of refused and accepted pulses, idle-mode strobes and security-bit sequences in one short run. The array depths stay at their defaults, so key indexing on the low six address bits is exercised with high address bits set.

// File: rtl/otp_mode_pkg.sv
package otp_mode_pkg;

  typedef enum logic [2:0] {
    MD_IDLE,
    MD_USER,
    MD_KEY,
    MD_SEC_A,
    MD_SEC_B
  } mode_e;

  localparam int CODE_W = 10;

  localparam logic [CODE_W-1:0] CODE_USER  = 10'h296;
  localparam logic [CODE_W-1:0] CODE_KEY   = 10'h292;
  localparam logic [CODE_W-1:0] CODE_SEC_A = 10'h29A;
  localparam logic [CODE_W-1:0] CODE_SEC_B = 10'h298;

  function automatic mode_e decode_code(input logic [CODE_W-1:0] c);
    case (c)
      CODE_USER:  return MD_USER;
      CODE_KEY:   return MD_KEY;
      CODE_SEC_A: return MD_SEC_A;
      CODE_SEC_B: return MD_SEC_B;
      default:    return MD_IDLE;
    endcase
  endfunction

  // A burn can only pull bits from 1 to 0.
  function automatic logic [7:0] burn_byte(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/otp_code_rx.sv
module otp_code_rx
  import otp_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ser_in,
  input  logic  sync_n,
  output mode_e mode,
  output logic  code_latch
);

  logic [CODE_W-1:0] shreg;
  logic              sync_q;

  assign code_latch = sync_n && !sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      sync_q <= 1'b1;
      mode   <= MD_IDLE;
    end else begin
      sync_q <= sync_n;
      if (!sync_n) begin
        shreg <= {shreg[CODE_W-2:0], ser_in};
      end else if (code_latch) begin
        mode <= decode_code(shreg);
      end
    end
  end

endmodule

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int PW_MIN = 540,
  parameter int PW_MAX = 660
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  output logic pulse_end,
  output logic pulse_in_range
);

  localparam int CNT_W = $clog2(PW_MAX + 2);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(PW_MAX + 1);
  localparam logic [CNT_W-1:0] LO  = CNT_W'(PW_MIN);
  localparam logic [CNT_W-1:0] HI  = CNT_W'(PW_MAX);

  logic [CNT_W-1:0] low_cnt;
  logic             prog_q;

  assign pulse_end      = prog_n && !prog_q;
  assign pulse_in_range = (low_cnt >= LO) && (low_cnt <= HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      prog_q  <= 1'b1;
    end else begin
      prog_q <= prog_n;
      if (!prog_n) begin
        if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_mode_pkg::*;
#(
  parameter int USER_DEPTH = 1024,
  parameter int KEY_DEPTH  = 64,
  parameter int ADDR_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_user,
  input  logic              wr_key,
  input  logic              wr_s1,
  input  logic              wr_s2,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        user_rd,
  output logic [7:0]        key_rd,
  output logic              sec1,
  output logic              sec2
);

  localparam int KEY_AW = $clog2(KEY_DEPTH);

  logic [7:0] user_mem [USER_DEPTH];
  logic [7:0] key_mem  [KEY_DEPTH];
  logic [KEY_AW-1:0] key_idx;

  assign key_idx = addr[KEY_AW-1:0];
  assign user_rd = user_mem[addr];
  assign key_rd  = key_mem[key_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < USER_DEPTH; i++) user_mem[i] <= 8'hFF;
    end else if (wr_user) begin
      user_mem[addr] <= burn_byte(user_mem[addr], din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < KEY_DEPTH; i++) key_mem[i] <= 8'hFF;
    end else if (wr_key) begin
      key_mem[key_idx] <= burn_byte(key_mem[key_idx], din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec1 <= 1'b0;
      sec2 <= 1'b0;
    end else begin
      if (wr_s1) sec1 <= 1'b1;
      if (wr_s2) sec2 <= 1'b1;
    end
  end

endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
  import otp_mode_pkg::*;
#(
  parameter int USER_DEPTH = 1024,
  parameter int KEY_DEPTH  = 64,
  parameter int PW_MIN     = 540,
  parameter int PW_MAX     = 660,
  localparam int ADDR_W    = $clog2(USER_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              sync_n,
  input  logic              prog_n,
  input  logic              hv_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              err_flag
);

  mode_e      mode;
  logic       code_latch;
  logic       pulse_end, pulse_in_range;
  logic       pulse_live, pulse_accept, pulse_reject;
  logic       wr_user, wr_key, wr_s1, wr_s2;
  logic [7:0] user_rd, key_rd;
  logic       sec1, sec2;
  logic [7:0] verify_byte;

  otp_code_rx u_rx (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sync_n(sync_n),
    .mode(mode), .code_latch(code_latch)
  );

  otp_pulse_timer #(.PW_MIN(PW_MIN), .PW_MAX(PW_MAX)) u_tmr (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n),
    .pulse_end(pulse_end), .pulse_in_range(pulse_in_range)
  );

  // Strobe matters only with high voltage and a real target selected.
  assign pulse_live   = pulse_end && hv_en && (mode != MD_IDLE);
  assign pulse_accept = pulse_live && pulse_in_range;
  assign pulse_reject = pulse_live && !pulse_in_range;

  assign wr_user = pulse_accept && (mode == MD_USER);
  assign wr_key  = pulse_accept && (mode == MD_KEY);
  assign wr_s1   = pulse_accept && (mode == MD_SEC_A);
  assign wr_s2   = pulse_accept && (mode == MD_SEC_B);

  otp_store #(.USER_DEPTH(USER_DEPTH), .KEY_DEPTH(KEY_DEPTH), .ADDR_W(ADDR_W)) u_st (
    .clk(clk), .rst_n(rst_n),
    .wr_user(wr_user), .wr_key(wr_key), .wr_s1(wr_s1), .wr_s2(wr_s2),
    .addr(addr), .din(din),
    .user_rd(user_rd), .key_rd(key_rd), .sec1(sec1), .sec2(sec2)
  );

  always_comb begin
    verify_byte = 8'h00;
    if (!hv_en) begin
      case (mode)
        MD_USER:  verify_byte = user_rd;
        MD_KEY:   verify_byte = key_rd;
        MD_SEC_A: verify_byte = {sec1, sec2, 6'b000000};
        default:  verify_byte = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= 8'h00;
      err_flag <= 1'b0;
    end else begin
      dout <= verify_byte;
      if (pulse_reject) err_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/otp_mode_ctrl_chk.sv
module otp_mode_ctrl_chk
  import otp_mode_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       hv_en,
  input logic [7:0] dout,
  input logic       err_flag,
  input mode_e      mode,
  input logic       pulse_reject,
  input logic       sec1,
  input logic       sec2
);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R8

  AST_REJECT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_reject |=> err_flag); // R7

  AST_SEC1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sec1 |=> sec1); // R5

  AST_SEC2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sec2 |=> sec2); // R5

  AST_SEC_VERIFY_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SEC_A && !hv_en) |=> (dout == {$past(sec1), $past(sec2), 6'b000000})); // R5

  AST_IDLE_DOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_IDLE) |=> (dout == 8'h00)); // R9

  AST_HV_DOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en |=> (dout == 8'h00)); // R11

endmodule

bind otp_mode_ctrl otp_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .dout(dout), .err_flag(err_flag),
  .mode(mode), .pulse_reject(pulse_reject), .sec1(sec1), .sec2(sec2)
);

// File: tb/sim_otp_mode_ctrl.sv
`timescale 1ns/1ps
module sim_otp_mode_ctrl;

  localparam int LO = 4;
  localparam int HI = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0, sync_n = 1'b1, prog_n = 1'b1, hv_en = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       err_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  otp_mode_ctrl #(.PW_MIN(LO), .PW_MAX(HI)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sync_n(sync_n), .prog_n(prog_n),
    .hv_en(hv_en), .addr(addr), .din(din), .dout(dout), .err_flag(err_flag)
  );

  // ---------------- behavioural reference model ----------------
  // kind: 0 idle, 1 user, 2 key, 3 secA (0x29A), 4 secB (0x298)
  int         m_kind;
  bit         bits_q[$];
  int         m_low;
  bit         m_sync_prev, m_prog_prev;
  byte        m_user[1024];
  byte        m_key[64];
  bit         m_s1, m_s2, m_err;
  logic [7:0] m_dout;
  bit         m_started = 0;

  function automatic int kind_of(input bit q[$]);
    int v = 0;
    int n = q.size();
    for (int i = (n > 10 ? n - 10 : 0); i < n; i++) v = (v << 1) | int'(q[i]);
    if (v == 'h296) return 1;
    if (v == 'h292) return 2;
    if (v == 'h29A) return 3;
    if (v == 'h298) return 4;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_kind = 0; bits_q = {}; m_low = 0; m_sync_prev = 1; m_prog_prev = 1;
      for (int i = 0; i < 1024; i++) m_user[i] = 8'hFF;
      for (int i = 0; i < 64; i++) m_key[i] = 8'hFF;
      m_s1 = 0; m_s2 = 0; m_err = 0; m_dout = 8'h00;
    end else begin
      m_started = 1;
      // verify byte from state before this edge
      if (hv_en) m_dout = 8'h00;
      else if (m_kind == 1) m_dout = m_user[addr];
      else if (m_kind == 2) m_dout = m_key[addr % 64];
      else if (m_kind == 3) m_dout = (m_s1 ? 8'h80 : 8'h00) | (m_s2 ? 8'h40 : 8'h00);
      else m_dout = 8'h00;
      // strobe
      if (!prog_n) begin
        if (m_low <= HI) m_low++;
      end else begin
        if (!m_prog_prev && hv_en && m_kind != 0) begin
          if (m_low < LO || m_low > HI) m_err = 1;
          else if (m_kind == 1) m_user[addr] = m_user[addr] & din;
          else if (m_kind == 2) m_key[addr % 64] = m_key[addr % 64] & din;
          else if (m_kind == 3) m_s1 = 1;
          else m_s2 = 1;
        end
        m_low = 0;
      end
      m_prog_prev = prog_n;
      // serial code
      if (!sync_n) bits_q.push_back(ser_in);
      else if (!m_sync_prev) m_kind = kind_of(bits_q);
      m_sync_prev = sync_n;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (m_started && rst_n && !done) begin
      checks++;
      if (dout !== m_dout || err_flag !== m_err) begin
        failures++;
        $display("FAIL R11 model compare t=%0t dout=%h/%0b exp=%h/%0b",
                 $time, dout, err_flag, m_dout, m_err);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_code(input logic [9:0] c);
    @(negedge clk);
    sync_n = 0;
    for (int i = 9; i >= 0; i--) begin
      ser_in = c[i];
      @(negedge clk);
    end
    sync_n = 1;
    ticks(2);
  endtask

  task automatic strobe(input int w);
    @(negedge clk);
    prog_n = 0;
    ticks(w);
    prog_n = 1;
    ticks(2);
  endtask

  task automatic peek(input logic h, input logic [9:0] a);
    hv_en = h; addr = a;
    ticks(2);
  endtask

  initial begin
    ticks(3);
    chk("R10 reset dout", dout, 8'h00);
    chk("R10 reset err", {7'b0, err_flag}, 8'h00);
    rst_n = 1;
    ticks(2);

    // user array, erased
    send_code(10'h296);
    peek(0, 10'd5);
    chk("R1 R6 erased user byte after code", dout, 8'hFF);

    // idle mode ignores strobes
    send_code(10'h123);
    hv_en = 1; addr = 10'd5; din = 8'h00;
    strobe(6);
    strobe(2);
    chk("R9 idle no err", {7'b0, err_flag}, 8'h00);
    peek(0, 10'd5);
    chk("R9 idle dout zero", dout, 8'h00);
    send_code(10'h296);
    peek(0, 10'd5);
    chk("R9 idle strobe left user byte", dout, 8'hFF);

    // burn and AND
    hv_en = 1; din = 8'hA5;
    ticks(1);
    chk("R11 dout zero under hv", dout, 8'h00);
    strobe(6);
    peek(0, 10'd5);
    chk("R2 user burn", dout, 8'hA5);
    hv_en = 1; din = 8'h3C;
    strobe(6);
    peek(0, 10'd5);
    chk("R6 AND burn", dout, 8'h24);
    addr = 10'd6;
    ticks(1);
    chk("R11 one-cycle verify", dout, 8'hFF);

    // width window
    hv_en = 1; addr = 10'd5; din = 8'h00;
    strobe(LO - 1);
    chk("R7 short pulse err", {7'b0, err_flag}, 8'h01);
    strobe(HI + 1);
    peek(0, 10'd5);
    chk("R7 refused pulses keep byte", dout, 8'h24);
    hv_en = 1; din = 8'h0F;
    strobe(LO);
    peek(0, 10'd5);
    chk("R7 min width accepted", dout, 8'h04);
    hv_en = 1; addr = 10'd7; din = 8'h77;
    strobe(HI);
    peek(0, 10'd7);
    chk("R7 max width accepted", dout, 8'h77);
    chk("R8 err still set", {7'b0, err_flag}, 8'h01);

    // key array
    send_code(10'h292);
    hv_en = 1; addr = 10'h3C5; din = 8'h81;
    strobe(5);
    peek(0, 10'h005);
    chk("R3 key indexed by low bits", dout, 8'h81);
    send_code(10'h296);
    peek(0, 10'h3C5);
    chk("R3 user array untouched by key burn", dout, 8'hFF);

    // security bits
    send_code(10'h29A);
    peek(0, 10'd0);
    chk("R5 sec verify erased", dout, 8'h00);
    send_code(10'h298);
    hv_en = 1; addr = 10'd5; din = 8'h00;
    strobe(5);
    peek(0, 10'd5);
    chk("R5 secB code verifies zero", dout, 8'h00);
    send_code(10'h29A);
    peek(0, 10'd0);
    chk("R4 sec2 on bit 6", dout, 8'h40);
    hv_en = 1; addr = 10'd5; din = 8'h00;
    strobe(5);
    peek(0, 10'd5);
    chk("R4 R5 both sec bits", dout, 8'hC0);
    send_code(10'h296);
    peek(0, 10'd5);
    chk("R4 sec burn ignored addr/din", dout, 8'h04);

    // reset clears everything
    @(negedge clk); rst_n = 0;
    ticks(2);
    rst_n = 1;
    send_code(10'h29A);
    peek(0, 10'd0);
    chk("R10 sec bits cleared", dout, 8'h00);
    chk("R10 err cleared", {7'b0, err_flag}, 8'h00);
    send_code(10'h296);
    peek(0, 10'd5);
    chk("R10 user erased", dout, 8'hFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule